// File: doc/BRIEF.md
# SD Error-Detection Check Word Generator

This block sits in a standard-definition 10-bit parallel video path, one word per clock. It runs two 16-bit check word accumulators, one over the active picture words and one over the whole field. Each accumulator is gated by a region strobe. At a field-end strobe the block latches both results and clears the accumulators for the next field.

A slot strobe marks the first word of a 12-word ancillary position. Within that slot the block parses any packet arriving from upstream. It compares the received check words with its own held results for the same field, then sets local error flags, upstream error flags and a missing-packet flag. It can also overwrite the slot with a freshly formatted packet carrying its own check words, the new flags and a checksum.

An enable control and a force control govern insertion. Outside insertion the video passes through with one clock of latency.

Top module: `edh_gen`

## Requirements
- R1: After reset `vid_out` is 0, all three status groups are 0, and both held check words are 0. A packet forced straight after reset therefore carries zero check words.
- R2: A check word is a CRC with polynomial x^16+x^12+x^6+1 (mask 0x1041) and initial value 0. Each gated word is shifted in bit 0 first, and the feedback bit is CRC bit 15 XOR the data bit.
- R3: The active accumulator takes only words with `act_rgn` high, and the field accumulator takes only words with `fld_rgn` high. On `field_end` both results are latched and the accumulators are cleared. The word present on the `field_end` cycle is not included in either result.
- R4: Outside an inserting slot, `vid_out` equals `vid_in` from the previous clock.
- R5: An inserted packet has 12 words, with the word on the `anc_slot` cycle as index 0:
  - 000h, 3FFh, 3FFh;
  - data ID F4h, block number 00h, data count 05h;
  - active check word low byte, then high byte;
  - field check word low byte, then high byte;
  - flag byte;
  - checksum.
- R6: Every formatted word with 8-bit payload b is {~p, p, b}, where p is the XOR of b. Bit 8 gives even parity and bit 9 is its inverse.
- R7: The checksum word takes the 9-bit sum s of bits 8:0 of words 3 to 10 and is {~s[8], s}.
- R8: With `edh_en` low, nothing is inserted, even with `edh_force` high.
- R9: With `edh_en` high and `edh_force` low, a slot is replaced only when words 0 to 3 arrive as 000h, 3FFh, 3FFh and the formatted data ID. Otherwise the slot passes through unchanged.
- R10: With `edh_en` and `edh_force` high, the whole slot is replaced whatever arrives. If no valid incoming packet was found, `pkt_missing` is set and the local and upstream flags are cleared.
- R11: For a valid incoming packet, `err_local[0]` is set when the received active check word differs from the held one, and `err_local[1]` is set for the field check word. Equal words clear the bit.
- R12: The flag byte uses bit 0 for local active, bit 1 for local field, bit 2 for upstream active and bit 3 for upstream field. For a valid incoming packet, `err_upstream[0]` is in-bit0 OR in-bit2 and `err_upstream[1]` is in-bit1 OR in-bit3. The status updates on the flag word (index 10), and the outgoing flag byte carries the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_in | input | 10 | Incoming video word |
| act_rgn | input | 1 | Word belongs to active picture |
| fld_rgn | input | 1 | Word belongs to the full-field region |
| field_end | input | 1 | Latch and clear accumulators |
| anc_slot | input | 1 | First word of the 12-word ancillary slot |
| edh_en | input | 1 | Allow packet insertion |
| edh_force | input | 1 | Insert even without an incoming packet |
| vid_out | output | 10 | Outgoing video word, one clock behind |
| err_local | output | 2 | Local mismatch flags {field, active} |
| err_upstream | output | 2 | Upstream-reported flags {field, active} |
| pkt_missing | output | 1 | Last slot held no valid packet |

## Verification
The hardest state to reach from the ports is a clean comparison. That needs an incoming packet whose check words equal exactly what the block computed for the previous field, which requires a bit-exact CRC of the gated words. The bench keeps its own serial CRC model of both regions while it drives a field. It then builds the incoming packet from that model, so one test sees the flags clear and another corrupts a single bit to see the flag set. Force insertion straight after reset exposes the zero-initialised held values.

// File: rtl/edh_pkg.sv
// Shared constants and helpers for the check word generator.
// Assumes 10-bit video words and 8-bit packet payload bytes.
package edh_pkg;
    localparam int WORD_W   = 10;
    localparam int CHK_W    = 16;
    localparam int PKT_LEN  = 12;
    localparam int IDX_W    = $clog2(PKT_LEN);
    localparam logic [CHK_W-1:0] CHK_POLY = 16'h1041;
    localparam logic [7:0] DCNT_BYTE = 8'h05;

    localparam logic [IDX_W-1:0] IX_ADF0 = 4'd0;
    localparam logic [IDX_W-1:0] IX_ADF1 = 4'd1;
    localparam logic [IDX_W-1:0] IX_ADF2 = 4'd2;
    localparam logic [IDX_W-1:0] IX_DID  = 4'd3;
    localparam logic [IDX_W-1:0] IX_BLK  = 4'd4;
    localparam logic [IDX_W-1:0] IX_DC   = 4'd5;
    localparam logic [IDX_W-1:0] IX_A0   = 4'd6;
    localparam logic [IDX_W-1:0] IX_A1   = 4'd7;
    localparam logic [IDX_W-1:0] IX_F0   = 4'd8;
    localparam logic [IDX_W-1:0] IX_F1   = 4'd9;
    localparam logic [IDX_W-1:0] IX_FLG  = 4'd10;
    localparam logic [IDX_W-1:0] IX_CS   = 4'd11;

    // Wrap a payload byte with even parity in bit 8 and its inverse in bit 9.
    function automatic logic [WORD_W-1:0] fmt_word(input logic [7:0] b);
        logic p;
        p = ^b;
        return {~p, p, b};
    endfunction

    // Advance a check word by one video word, bit 0 first.
    function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] c,
                                                  input logic [WORD_W-1:0] w);
        logic [CHK_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[CHK_W-1] ^ w[i];
            r  = {r[CHK_W-2:0], 1'b0};
            if (fb) r = r ^ CHK_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/edh_chk_acc.sv
// One region accumulator: folds gated words into a running check word and
// hands the result to a held register on the field-end strobe.
// Assumes field_end is a single-cycle strobe; its word is not folded in.
module edh_chk_acc
    import edh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              gate,
    input  logic              field_end,
    output logic [CHK_W-1:0]  held
);
    logic [CHK_W-1:0] acc_q;

    // Accumulate, or latch and clear at the field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            held  <= '0;
        end else if (field_end) begin
            held  <= acc_q;
            acc_q <= '0;
        end else if (gate) begin
            acc_q <= chk_step(acc_q, word);
        end
    end

    assert_acc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !field_end) |=> $stable(acc_q));
    assert_held_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> $stable(held));
endmodule

// File: rtl/edh_slot_ctrl.sv
// Tracks the 12-word ancillary slot, recognises a valid incoming packet
// header and decides word by word whether the slot is overwritten.
// Assumes anc_slot marks index 0; a new strobe restarts the slot.
module edh_slot_ctrl
    import edh_pkg::*;
#(
    parameter logic [7:0] DID_CODE = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              anc_slot,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              edh_en,
    input  logic              edh_force,
    output logic              slot_active,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              pkt_present,
    output logic              ins_now
);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(PKT_LEN - 1);

    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;
    logic             hdr_q, pres_q, ins_q;
    logic             hdr_now;

    assign slot_active = anc_slot | busy_q;
    assign slot_idx    = anc_slot ? '0 : cnt_q;

    // Running check of the three flag words at the head of the slot.
    always_comb begin
        case (slot_idx)
            IX_ADF0:          hdr_now = (vid_in == 10'h000);
            IX_ADF1, IX_ADF2: hdr_now = hdr_q && (vid_in == 10'h3FF);
            default:          hdr_now = hdr_q;
        endcase
    end

    // Packet is present when the header and data ID both match.
    always_comb begin
        if (slot_idx == IX_DID) pkt_present = hdr_q && (vid_in == fmt_word(DID_CODE));
        else                    pkt_present = pres_q;
    end

    // Replace the word when enabled and either forced or a packet is present.
    always_comb begin
        if (!slot_active || !edh_en) ins_now = 1'b0;
        else if (slot_idx < IX_DID)  ins_now = edh_force;
        else if (slot_idx == IX_DID) ins_now = edh_force || pkt_present;
        else                         ins_now = ins_q;
    end

    // Slot position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (anc_slot) begin
            busy_q <= 1'b1;
            cnt_q  <= IDX_W'(1);
        end else if (busy_q) begin
            if (cnt_q == LAST_IX) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + IDX_W'(1);
            end
        end
    end

    // Header, presence and insertion state held across the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= 1'b0;
            pres_q <= 1'b0;
            ins_q  <= 1'b0;
        end else if (slot_active) begin
            if (slot_idx <= IX_ADF2) hdr_q <= hdr_now;
            if (slot_idx == IX_DID) begin
                pres_q <= pkt_present;
                ins_q  <= ins_now;
            end
        end
    end

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_active |-> (slot_idx <= LAST_IX));
    assert_slot_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == LAST_IX && !anc_slot) |=> !busy_q);
endmodule

// File: rtl/edh_pkt_fmt.sv
// Builds the outgoing packet words, captures the received check words and
// flag byte, and updates the three status groups at the flag position.
// Assumes slot index and presence come from the slot controller.
module edh_pkt_fmt
    import edh_pkg::*;
#(
    parameter logic [7:0] DID_CODE = 8'hF4,
    parameter logic [7:0] BLK_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_active,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [7:0]        rx_byte,
    input  logic              pkt_present,
    input  logic [CHK_W-1:0]  held_act,
    input  logic [CHK_W-1:0]  held_fld,
    output logic [WORD_W-1:0] gen_word,
    output logic [1:0]        err_local,
    output logic [1:0]        err_upstream,
    output logic              pkt_missing
);
    logic [CHK_W-1:0] rx_act_q, rx_fld_q;
    logic [8:0]       sum_q;
    logic [1:0]       loc_now, up_now;

    // Flags that the current packet yields.
    always_comb begin
        if (pkt_present) begin
            loc_now = {rx_fld_q != held_fld, rx_act_q != held_act};
            up_now  = {rx_byte[1] | rx_byte[3], rx_byte[0] | rx_byte[2]};
        end else begin
            loc_now = 2'b00;
            up_now  = 2'b00;
        end
    end

    // Select the outgoing word for the current slot index.
    always_comb begin
        case (slot_idx)
            IX_ADF0: gen_word = 10'h000;
            IX_ADF1: gen_word = 10'h3FF;
            IX_ADF2: gen_word = 10'h3FF;
            IX_DID:  gen_word = fmt_word(DID_CODE);
            IX_BLK:  gen_word = fmt_word(BLK_CODE);
            IX_DC:   gen_word = fmt_word(DCNT_BYTE);
            IX_A0:   gen_word = fmt_word(held_act[7:0]);
            IX_A1:   gen_word = fmt_word(held_act[15:8]);
            IX_F0:   gen_word = fmt_word(held_fld[7:0]);
            IX_F1:   gen_word = fmt_word(held_fld[15:8]);
            IX_FLG:  gen_word = fmt_word({4'b0000, up_now, loc_now});
            default: gen_word = {~sum_q[8], sum_q};
        endcase
    end

    // Capture received check bytes from the incoming packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_act_q <= '0;
            rx_fld_q <= '0;
        end else if (slot_active) begin
            case (slot_idx)
                IX_A0:   rx_act_q[7:0]  <= rx_byte;
                IX_A1:   rx_act_q[15:8] <= rx_byte;
                IX_F0:   rx_fld_q[7:0]  <= rx_byte;
                IX_F1:   rx_fld_q[15:8] <= rx_byte;
                default: ;
            endcase
        end
    end

    // Running checksum over data ID through the flag word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     sum_q <= '0;
        else if (slot_active && slot_idx == IX_DID)     sum_q <= gen_word[8:0];
        else if (slot_active && slot_idx > IX_DID && slot_idx <= IX_FLG)
                                                        sum_q <= sum_q + gen_word[8:0];
    end

    // Status groups update on the flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_local    <= 2'b00;
            err_upstream <= 2'b00;
            pkt_missing  <= 1'b0;
        end else if (slot_active && slot_idx == IX_FLG) begin
            err_local    <= loc_now;
            err_upstream <= up_now;
            pkt_missing  <= !pkt_present;
        end
    end

    assert_missing_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_missing |-> (err_local == 2'b00 && err_upstream == 2'b00));
    assert_cs_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_active && slot_idx == IX_CS) |-> (gen_word[9] != gen_word[8]));
    assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_active && slot_idx == IX_FLG) |=> $stable(err_local) && $stable(pkt_missing));
endmodule

// File: rtl/edh_gen.sv
// Top: two region accumulators, slot control, packet formatter and the
// output register that selects between pass-through and the new packet.
// Assumes one video word per clock and strobes aligned with their word.
module edh_gen
    import edh_pkg::*;
#(
    parameter logic [7:0] DID_CODE = 8'hF4,
    parameter logic [7:0] BLK_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              act_rgn,
    input  logic              fld_rgn,
    input  logic              field_end,
    input  logic              anc_slot,
    input  logic              edh_en,
    input  logic              edh_force,
    output logic [WORD_W-1:0] vid_out,
    output logic [1:0]        err_local,
    output logic [1:0]        err_upstream,
    output logic              pkt_missing
);
    localparam int N_RGN = 2;

    logic [N_RGN-1:0] rgn_gate;
    logic [CHK_W-1:0] held [N_RGN];
    logic             slot_active, pkt_present, ins_now;
    logic [IDX_W-1:0] slot_idx;
    logic [WORD_W-1:0] gen_word;

    assign rgn_gate = {fld_rgn, act_rgn};

    for (genvar g = 0; g < N_RGN; g++) begin : g_acc
        edh_chk_acc u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .word      (vid_in),
            .gate      (rgn_gate[g]),
            .field_end (field_end),
            .held      (held[g])
        );
    end

    edh_slot_ctrl #(.DID_CODE(DID_CODE)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .anc_slot    (anc_slot),
        .vid_in      (vid_in),
        .edh_en      (edh_en),
        .edh_force   (edh_force),
        .slot_active (slot_active),
        .slot_idx    (slot_idx),
        .pkt_present (pkt_present),
        .ins_now     (ins_now)
    );

    edh_pkt_fmt #(.DID_CODE(DID_CODE), .BLK_CODE(BLK_CODE)) u_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_active  (slot_active),
        .slot_idx     (slot_idx),
        .rx_byte      (vid_in[7:0]),
        .pkt_present  (pkt_present),
        .held_act     (held[0]),
        .held_fld     (held[1]),
        .gen_word     (gen_word),
        .err_local    (err_local),
        .err_upstream (err_upstream),
        .pkt_missing  (pkt_missing)
    );

    // Output register: new packet word or the delayed input word.
    always_ff @(posedge clk) begin
        if (!rst_n) vid_out <= '0;
        else        vid_out <= ins_now ? gen_word : vid_in;
    end

    assert_pass_outside_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_active |=> (vid_out == $past(vid_in)));
    assert_disabled_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !edh_en |=> (vid_out == $past(vid_in)));
endmodule

// File: tb/tb_edh_gen.sv
// Directed bench: each task drives one scenario and checks its own results.
module tb_edh_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] vid_in;
    logic       act_rgn, fld_rgn, field_end, anc_slot, edh_en, edh_force;
    logic [9:0] vid_out;
    logic [1:0] err_local, err_upstream;
    logic       pkt_missing;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] m_acc_a, m_acc_f, m_held_a, m_held_f;
    logic [9:0]  in_pkt  [12];
    logic [9:0]  exp_pkt [12];

    always #5 clk = ~clk;

    edh_gen dut (
        .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .act_rgn(act_rgn),
        .fld_rgn(fld_rgn), .field_end(field_end), .anc_slot(anc_slot),
        .edh_en(edh_en), .edh_force(edh_force), .vid_out(vid_out),
        .err_local(err_local), .err_upstream(err_upstream), .pkt_missing(pkt_missing)
    );

    function automatic logic [9:0] fw(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    function automatic logic [15:0] crc16(input logic [15:0] c, input logic [9:0] w);
        logic [15:0] r = c;
        for (int i = 0; i < 10; i++) begin
            if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1041;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word at the falling edge; return just after the next rising edge.
    task automatic put(input logic [9:0] w, input logic a, input logic f,
                       input logic fe, input logic ps);
        @(negedge clk);
        vid_in = w; act_rgn = a; fld_rgn = f; field_end = fe; anc_slot = ps;
        @(posedge clk);
        #1;
    endtask

    // Build the expected inserted packet from the model (R5, R6, R7).
    task automatic build_exp(input logic [7:0] flag_byte);
        logic [8:0] s;
        exp_pkt[0] = 10'h000; exp_pkt[1] = 10'h3FF; exp_pkt[2] = 10'h3FF;
        exp_pkt[3] = fw(8'hF4); exp_pkt[4] = fw(8'h00); exp_pkt[5] = fw(8'h05);
        exp_pkt[6] = fw(m_held_a[7:0]); exp_pkt[7] = fw(m_held_a[15:8]);
        exp_pkt[8] = fw(m_held_f[7:0]); exp_pkt[9] = fw(m_held_f[15:8]);
        exp_pkt[10] = fw(flag_byte);
        s = '0;
        for (int i = 3; i <= 10; i++) s = s + exp_pkt[i][8:0];
        exp_pkt[11] = {~s[8], s};
    endtask

    // Build a well-formed incoming packet carrying given check words and flags.
    task automatic build_in(input logic [15:0] a, input logic [15:0] f, input logic [7:0] flg);
        logic [8:0] s;
        in_pkt[0] = 10'h000; in_pkt[1] = 10'h3FF; in_pkt[2] = 10'h3FF;
        in_pkt[3] = fw(8'hF4); in_pkt[4] = fw(8'h00); in_pkt[5] = fw(8'h05);
        in_pkt[6] = fw(a[7:0]); in_pkt[7] = fw(a[15:8]);
        in_pkt[8] = fw(f[7:0]); in_pkt[9] = fw(f[15:8]);
        in_pkt[10] = fw(flg);
        s = '0;
        for (int i = 3; i <= 10; i++) s = s + in_pkt[i][8:0];
        in_pkt[11] = {~s[8], s};
    endtask

    // Run one slot, comparing each output word with the replacement or input.
    task automatic run_slot(input bit expect_ins, input string tag);
        int bad = 0;
        logic [9:0] first_act = '0, first_exp = '0;
        for (int i = 0; i < 12; i++) begin
            logic [9:0] e;
            put(in_pkt[i], 1'b0, 1'b0, 1'b0, i == 0);
            e = expect_ins ? exp_pkt[i] : in_pkt[i];
            if (vid_out !== e) begin
                if (bad == 0) begin first_act = vid_out; first_exp = e; end
                bad++;
            end
            if (expect_ins) check({tag, " word"}, {22'd0, vid_out}, {22'd0, exp_pkt[i]});
        end
        if (!expect_ins) check(tag, {22'd0, first_act}, {22'd0, first_exp});
        put(10'h040, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // Drive a field of n words with the active region inside the full region (R2, R3, R4).
    task automatic run_field(input int seed, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            logic [9:0] w;
            logic a;
            w = 10'((seed + i * 97) & 32'h3FF);
            a = (i >= 2) && (i < n - 2);
            put(w, a, 1'b1, 1'b0, 1'b0);
            if (a) m_acc_a = crc16(m_acc_a, w);
            m_acc_f = crc16(m_acc_f, w);
            if (vid_out !== w) bad++;
        end
        check("R4 pass-through mismatches", bad, 0);
        // Field-end word is excluded from both results (R3).
        put(10'h155, 1'b1, 1'b1, 1'b1, 1'b0);
        m_held_a = m_acc_a; m_held_f = m_acc_f;
        m_acc_a = '0; m_acc_f = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        vid_in = 10'h2AA; act_rgn = 0; fld_rgn = 0; field_end = 0; anc_slot = 0;
        edh_en = 0; edh_force = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset vid_out", {22'd0, vid_out}, 32'd0);
        check("R1 reset status", {27'd0, err_local, err_upstream, pkt_missing}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        m_acc_a = '0; m_acc_f = '0; m_held_a = '0; m_held_f = '0;
    endtask

    // Forced packet right after reset: zero check words, missing flag (R1, R10).
    task automatic t_force_after_reset;
        edh_en = 1; edh_force = 1;
        for (int i = 0; i < 12; i++) in_pkt[i] = 10'h040;
        build_exp(8'h00);
        check("R1 zero check word", {22'd0, exp_pkt[6]}, 32'h200);
        run_slot(1'b1, "R10 R5 R6 R7 forced after reset");
        check("R10 missing flag", {31'd0, pkt_missing}, 32'd1);
        check("R10 flags cleared", {28'd0, err_local, err_upstream}, 32'd0);
    endtask

    // Matching incoming packet: flags clear, check words from the model (R2, R3, R11, R9).
    task automatic t_match;
        edh_en = 1; edh_force = 0;
        run_field(11, 40);
        build_in(m_held_a, m_held_f, 8'h00);
        build_exp(8'h00);
        run_slot(1'b1, "R2 R3 R9 R5 R7 match packet");
        check("R11 local flags on match", {30'd0, err_local}, 32'd0);
        check("R12 upstream flags clear", {30'd0, err_upstream}, 32'd0);
        check("R10 missing low with packet", {31'd0, pkt_missing}, 32'd0);
    endtask

    // Corrupted active check word and upstream field flag (R11, R12).
    task automatic t_mismatch;
        edh_en = 1; edh_force = 0;
        run_field(300, 33);
        build_in(m_held_a ^ 16'h0100, m_held_f, 8'h08);
        build_exp(8'h09);
        run_slot(1'b1, "R11 R12 mismatch packet");
        check("R11 active mismatch flag", {30'd0, err_local}, 32'd1);
        check("R12 upstream field flag", {30'd0, err_upstream}, 32'd2);
    endtask

    // Enable low with force high: slot passes unchanged (R8).
    task automatic t_disabled;
        edh_en = 0; edh_force = 1;
        run_field(77, 20);
        build_in(16'h1234, 16'h5678, 8'h03);
        run_slot(1'b0, "R8 disabled pass-through");
    endtask

    // Enable without force and no packet: pass-through, missing set (R9).
    task automatic t_no_packet;
        edh_en = 1; edh_force = 0;
        for (int i = 0; i < 12; i++) in_pkt[i] = 10'(32'h100 + i * 5);
        in_pkt[0] = 10'h000; in_pkt[1] = 10'h3FF;
        run_slot(1'b0, "R9 no packet pass-through");
        check("R9 missing flag", {31'd0, pkt_missing}, 32'd1);
    endtask

    initial begin
        t_reset;
        t_force_after_reset;
        t_match;
        t_mismatch;
        t_disabled;
        t_no_packet;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule